// File: doc/BRIEF.md
# Camera Bring-up and Frame Power Sequencer

This block sits between a host and an image sensor's control path. The host programs a small bank of 8-bit configuration registers. These hold four sensor register/value pairs for frame size and colour, one pair that wakes the sensor, one pair that puts it to sleep, the image width divided by four and the byte count per pixel. Because the sensor's register numbers and values are all programmable, one build of the block can drive sensors from any maker.

An Init rising edge starts bring-up. The block pulls the sensor reset low for a short pulse and releases it. It then waits a settling interval of 2000 clocks before it issues the programmed configuration writes and the wake write. Each write is a request to a separate serial write engine. The request carries the fixed slave address, the register number and the value, and it is held until the engine returns a one-cycle done pulse.

Once a frame-complete pulse arrives, the block sends the sleep write on its own to save power. It then parks until the host raises the frame request again, which wakes the sensor for the next frame. A host reset returns everything to idle.

Top module: `cam_seq_top`

## Requirements
- R1: A write with `cfg_wr` high at a clock edge stores `cfg_data` at `cfg_addr` (2,3 sleep register/value; 4,5 wake register/value; 6..13 the four configuration pairs in order, register at the even address; 14 width/4; 15 bytes per pixel). Registers 14 and 15 appear on `img_width_q` and `bytes_per_px` from the next cycle. Reset clears all of them to 0.
- R2: A rising edge on the asynchronous `init_req`, seen through a two-flop synchronizer while the block is idle, drives `sensor_rst_n` low for exactly RST_PULSE cycles. No command is requested while it is low.
- R3: The first command request after reset release comes SETTLE_CYCLES+1 cycles after release, plus one cycle for each skipped slot before it.
- R4: Bring-up requests configuration pairs 1 to 4 in order and then the wake pair. Each request carries `slave_addr`, the stored register number and the value. A slot whose register number is 0 is skipped and never requested.
- R5: `cmd_req` stays high with stable fields until a cycle with `cmd_done` high. It is low in the following cycle.
- R6: After the wake write completes, a `frame_done` pulse causes the sleep pair to be requested.
- R7: After the sleep write completes, a rising edge on the asynchronous `frame_req` causes the wake pair to be requested again. The next `frame_done` then causes another sleep request.
- R8: `init_req` has no effect unless the block is idle. `frame_req` has no effect unless the block is parked after sleep. `frame_done` has no effect unless the block is waiting for a frame after wake.
- R9: While `rst` is high, `sensor_rst_n` is high, `cmd_req` is low and the registers are cleared. After `rst` falls, a new `init_req` edge restarts the full bring-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor-side clock |
| rst | input | 1 | Host reset, active high, asynchronous |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_data | input | 8 | Configuration write data |
| init_req | input | 1 | Asynchronous start of bring-up |
| frame_req | input | 1 | Asynchronous request for the next frame |
| frame_done | input | 1 | One-cycle frame-complete pulse |
| slave_addr | input | 8 | Sensor slave address, held constant |
| cmd_done | input | 1 | Write engine completion pulse |
| sensor_rst_n | output | 1 | Active-low sensor reset |
| cmd_req | output | 1 | Register-write request |
| cmd_slave | output | 8 | Slave address of the request |
| cmd_reg | output | 8 | Sensor register number of the request |
| cmd_data | output | 8 | Value to write |
| img_width_q | output | 8 | Stored image width / 4 |
| bytes_per_px | output | 8 | Stored bytes per pixel |

## Verification
On every cycle, the assertions check the request handshake, the register-file writes, and the rule that no request happens during the reset pulse or within the settling window. They also check that a request never carries register number 0. Only the bench scenarios can show the order of commands over a full bring-up, the skip timing, and the sleep/wake loop driven by `frame_done` and `frame_req`. The same holds for events that have no effect in the wrong phase, and for a restart after a host reset part way through the sequence.

// File: rtl/cam_seq_pkg.sv
package cam_seq_pkg;
   localparam int ADR_SLEEP = 2;
   localparam int ADR_WAKE  = 4;
   localparam int ADR_CMD0  = 6;
   localparam int ADR_WIDTH = 14;
   localparam int ADR_BPP   = 15;
   localparam int NUM_CMD   = 4;

   localparam logic [2:0] SLOT_WAKE  = 3'(NUM_CMD);
   localparam logic [2:0] SLOT_SLEEP = 3'(NUM_CMD + 1);

   typedef enum logic [2:0] {
      ST_IDLE, ST_RST, ST_SETTLE, ST_PICK, ST_SEND, ST_WAITF, ST_PARK
   } seq_st_e;

   // register-number location of a command slot; its value sits one above
   function automatic logic [3:0] slot_reg_idx(input logic [2:0] s);
      if (s == SLOT_WAKE)       return 4'(ADR_WAKE);
      else if (s == SLOT_SLEEP) return 4'(ADR_SLEEP);
      else                      return 4'(ADR_CMD0 + 2 * int'(s));
   endfunction
endpackage

// File: rtl/cam_cfg_regs.sv
module cam_cfg_regs #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         wr,
   input  logic [AW-1:0]                addr,
   input  logic [DW-1:0]                data,
   output logic [(1<<AW)-1:0][DW-1:0]   regs_q
);
   import cam_seq_pkg::*;
   localparam int NREG = 1 << AW;

   generate
      if (AW != 4) begin : g_bad_aw
         initial $error("cam_cfg_regs: address map needs AW == 4");
      end
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         if (i < ADR_SLEEP) begin : g_hole
            assign regs_q[i] = '0;
         end else begin : g_store
            always_ff @(posedge clk or posedge rst) begin
               if (rst)                          regs_q[i] <= '0;
               else if (wr && addr == AW'(i))    regs_q[i] <= data;
            end
            // R1
            reg_store_chk: assert property (@(posedge clk) disable iff (rst)
               (wr && addr == AW'(i)) |=> regs_q[i] == $past(data));
            // R1
            reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
               !(wr && addr == AW'(i)) |=> $stable(regs_q[i]));
         end
      end
   endgenerate
endmodule

// File: rtl/cam_sync_rise.sv
module cam_sync_rise #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] rise_o
);
   generate
      if (W < 1) begin : g_bad_w
         initial $error("cam_sync_rise: W must be at least 1");
      end
      for (genvar b = 0; b < W; b++) begin : g_bit
         logic s1, s2, s3;
         always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
               s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
            end else begin
               s1 <= async_i[b]; s2 <= s1; s3 <= s2;
            end
         end
         assign rise_o[b] = s2 & ~s3;
      end
   endgenerate
endmodule

// File: rtl/cam_seq_fsm.sv
module cam_seq_fsm #(
   parameter int AW            = 4,
   parameter int DW            = 8,
   parameter int RST_PULSE     = 8,
   parameter int SETTLE_CYCLES = 2000
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        init_rise,
   input  logic                        frame_rise,
   input  logic                        frame_done,
   input  logic                        cmd_done,
   input  logic [DW-1:0]               slave_addr,
   input  logic [(1<<AW)-1:0][DW-1:0]  regs,
   output logic                        sensor_rst_n,
   output logic                        cmd_req,
   output logic [DW-1:0]               cmd_slave,
   output logic [DW-1:0]               cmd_reg,
   output logic [DW-1:0]               cmd_data
);
   import cam_seq_pkg::*;
   localparam int CNT_MAX = (RST_PULSE > SETTLE_CYCLES) ? RST_PULSE : SETTLE_CYCLES;
   localparam int CW      = $clog2(CNT_MAX + 2);
   localparam logic [CW-1:0] RP_M1 = CW'(RST_PULSE - 1);
   localparam logic [CW-1:0] ST_M1 = CW'(SETTLE_CYCLES - 1);
   localparam logic [CW:0]   GAP_MAX = (CW+1)'(SETTLE_CYCLES + 1);

   generate
      if (RST_PULSE < 1 || SETTLE_CYCLES < 1) begin : g_bad_time
         initial $error("cam_seq_fsm: pulse and settle lengths must be positive");
      end
   endgenerate

   seq_st_e         st, adv_st;
   logic [2:0]      slot, adv_slot;
   logic [CW-1:0]   cnt;
   logic [3:0]      ridx;
   logic [DW-1:0]   cur_reg, cur_dat;
   logic            rstn_q, req_q;
   logic [DW-1:0]   reg_q, dat_q, slv_q;

   always_comb begin
      ridx    = slot_reg_idx(slot);
      cur_reg = regs[ridx];
      cur_dat = regs[4'(ridx + 4'd1)];
      if (slot == SLOT_WAKE) begin
         adv_st = ST_WAITF; adv_slot = slot;
      end else if (slot == SLOT_SLEEP) begin
         adv_st = ST_PARK;  adv_slot = slot;
      end else begin
         adv_st = ST_PICK;  adv_slot = 3'(slot + 3'd1);
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         st <= ST_IDLE; slot <= '0; cnt <= '0;
         rstn_q <= 1'b1; req_q <= 1'b0;
         reg_q <= '0; dat_q <= '0; slv_q <= '0;
      end else begin
         case (st)
            ST_IDLE: if (init_rise) begin
               st <= ST_RST; cnt <= '0; rstn_q <= 1'b0;
            end
            ST_RST: if (cnt == RP_M1) begin
               st <= ST_SETTLE; cnt <= '0; rstn_q <= 1'b1;
            end else cnt <= cnt + 1'b1;
            ST_SETTLE: if (cnt == ST_M1) begin
               st <= ST_PICK; slot <= '0;
            end else cnt <= cnt + 1'b1;
            ST_PICK: if (cur_reg == '0) begin
               st <= adv_st; slot <= adv_slot;
            end else begin
               st <= ST_SEND; req_q <= 1'b1;
               reg_q <= cur_reg; dat_q <= cur_dat; slv_q <= slave_addr;
            end
            ST_SEND: if (cmd_done) begin
               req_q <= 1'b0; st <= adv_st; slot <= adv_slot;
            end
            ST_WAITF: if (frame_done) begin
               st <= ST_PICK; slot <= SLOT_SLEEP;
            end
            ST_PARK: if (frame_rise) begin
               st <= ST_PICK; slot <= SLOT_WAKE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign sensor_rst_n = rstn_q;
   assign cmd_req      = req_q;
   assign cmd_reg      = reg_q;
   assign cmd_data     = dat_q;
   assign cmd_slave    = slv_q;

   // cycles since the sensor reset was released, saturating
   logic [CW:0] gap_q;
   always_ff @(posedge clk or posedge rst) begin
      if (rst)                  gap_q <= GAP_MAX;
      else if (!sensor_rst_n)   gap_q <= '0;
      else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
   end

   // R3
   settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
      cmd_req |-> gap_q == GAP_MAX);
   // R2
   rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !sensor_rst_n |-> !cmd_req);
   // R4
   reg_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      cmd_req |-> cmd_reg != '0);
   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_req && !cmd_done) |=> (cmd_req && $stable(cmd_reg) &&
                                  $stable(cmd_data) && $stable(cmd_slave)));
   // R5
   req_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_req && cmd_done) |=> !cmd_req);
endmodule

// File: rtl/cam_seq_top.sv
module cam_seq_top #(
   parameter int AW            = 4,
   parameter int DW            = 8,
   parameter int RST_PULSE     = 8,
   parameter int SETTLE_CYCLES = 2000
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cfg_wr,
   input  logic [AW-1:0] cfg_addr,
   input  logic [DW-1:0] cfg_data,
   input  logic          init_req,
   input  logic          frame_req,
   input  logic          frame_done,
   input  logic [DW-1:0] slave_addr,
   input  logic          cmd_done,
   output logic          sensor_rst_n,
   output logic          cmd_req,
   output logic [DW-1:0] cmd_slave,
   output logic [DW-1:0] cmd_reg,
   output logic [DW-1:0] cmd_data,
   output logic [DW-1:0] img_width_q,
   output logic [DW-1:0] bytes_per_px
);
   import cam_seq_pkg::*;

   logic [(1<<AW)-1:0][DW-1:0] regs;
   logic [1:0]                 rises;

   cam_cfg_regs #(.AW(AW), .DW(DW)) u_regs (
      .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr),
      .data(cfg_data), .regs_q(regs));

   cam_sync_rise #(.W(2)) u_sync (
      .clk(clk), .rst(rst), .async_i({frame_req, init_req}), .rise_o(rises));

   cam_seq_fsm #(.AW(AW), .DW(DW), .RST_PULSE(RST_PULSE),
                 .SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
      .clk(clk), .rst(rst), .init_rise(rises[0]), .frame_rise(rises[1]),
      .frame_done(frame_done), .cmd_done(cmd_done), .slave_addr(slave_addr),
      .regs(regs), .sensor_rst_n(sensor_rst_n), .cmd_req(cmd_req),
      .cmd_slave(cmd_slave), .cmd_reg(cmd_reg), .cmd_data(cmd_data));

   assign img_width_q  = regs[ADR_WIDTH];
   assign bytes_per_px = regs[ADR_BPP];
endmodule

// File: tb/cam_seq_top_tb.sv
module cam_seq_top_tb;
   localparam int RP = 8;
   localparam int ST = 2000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cfg_wr = 1'b0;
   logic [3:0] cfg_addr = '0;
   logic [7:0] cfg_data = '0;
   logic init_req = 1'b0, frame_req = 1'b0, frame_done = 1'b0;
   logic [7:0] slave_addr = 8'h42;
   logic cmd_done = 1'b0;
   logic sensor_rst_n, cmd_req;
   logic [7:0] cmd_slave, cmd_reg, cmd_data, img_width_q, bytes_per_px;

   always #5 clk = ~clk;

   cam_seq_top #(.RST_PULSE(RP), .SETTLE_CYCLES(ST)) u_dut (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .init_req(init_req), .frame_req(frame_req),
      .frame_done(frame_done), .slave_addr(slave_addr), .cmd_done(cmd_done),
      .sensor_rst_n(sensor_rst_n), .cmd_req(cmd_req), .cmd_slave(cmd_slave),
      .cmd_reg(cmd_reg), .cmd_data(cmd_data), .img_width_q(img_width_q),
      .bytes_per_px(bytes_per_px));

   int nchk = 0, nerr = 0, cycle = 0;
   bit timed_out = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
   endtask

   // ---------------- behavioural reference model ----------------
   // phases: 0 idle, 1 bring-up/wake pending, 2 waiting frame, 3 sleep pending, 4 parked
   logic [7:0]  sh [16];
   logic [17:0] q [$];   // {kind, reg, data}; kind 0 cfg, 1 wake, 2 sleep
   int ph = 0, lowcnt = 0;
   bit hi1, hi2, hi3, hf1, hf2, hf3;

   task automatic push_slot(input logic [1:0] kind, input int a);
      if (sh[a] != 8'h00) q.push_back({kind, sh[a], sh[a+1]});
   endtask

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 16; i++) sh[i] = 8'h00;
         q.delete(); ph = 0; lowcnt = 0;
         {hi1, hi2, hi3, hf1, hf2, hf3} = '0;
      end else begin
         bit ir, fr;
         logic [17:0] it;
         ir = hi2 && !hi3; fr = hf2 && !hf3;
         hi3 = hi2; hi2 = hi1; hi1 = init_req;
         hf3 = hf2; hf2 = hf1; hf1 = frame_req;
         if (cfg_wr && cfg_addr >= 4'd2) sh[cfg_addr] = cfg_data;
         if (ph == 2 && frame_done) begin push_slot(2, 2); ph = 3; end
         if (ph == 4 && fr) begin push_slot(1, 4); ph = 1; end
         if (ph == 0 && ir) begin
            lowcnt = RP;
            for (int s = 0; s < 4; s++) push_slot(0, 6 + 2 * s);
            push_slot(1, 4);
            ph = 1;
         end else if (lowcnt > 0) lowcnt--;
         if (cmd_done && q.size() > 0) begin
            it = q.pop_front();
            if (it[17:16] == 2'd1) ph = 2;
            else if (it[17:16] == 2'd2) ph = 4;
         end
      end
   end

   // ---------------- per-clock comparison and write-engine responder ----------------
   int lat = 2, rc = 0, n_sent = 0, rel_cyc = 0, exp_gap = 0;
   bit prev_req = 0, prev_rstn = 1, gap_arm = 0;

   always @(negedge clk) begin
      cycle++;
      if (cycle > 150000 && !timed_out) begin
         timed_out = 1;
         chk(0, "watchdog", "run did not end", cycle, 150000);
         report();
         $finish;
      end
      if (!rst) begin
         // R2 R8: reset pulse length and no pulse outside idle
         chk(sensor_rst_n == (lowcnt == 0), "R2/R8", "sensor_rst_n",
             sensor_rst_n, lowcnt == 0);
         // R1
         chk(img_width_q == sh[14], "R1", "img_width_q", img_width_q, sh[14]);
         chk(bytes_per_px == sh[15], "R1", "bytes_per_px", bytes_per_px, sh[15]);
         if (sensor_rst_n && !prev_rstn) begin rel_cyc = cycle; gap_arm = 1; end
         if (cmd_req && !sensor_rst_n) chk(0, "R2", "request during reset", 1, 0);
         if (cmd_done) chk(!cmd_req, "R5", "request after done", cmd_req, 0);
         if (cmd_req && !cmd_done) begin
            if (q.size() == 0) begin
               chk(0, "R8", "request with nothing expected", cmd_reg, 0);
            end else begin
               if (!prev_req) begin
                  n_sent++;
                  chk(cmd_reg == q[0][15:8], "R4", "cmd_reg", cmd_reg, q[0][15:8]);
                  chk(cmd_data == q[0][7:0], "R4", "cmd_data", cmd_data, q[0][7:0]);
                  chk(cmd_slave == slave_addr, "R4", "cmd_slave", cmd_slave, slave_addr);
                  if (gap_arm) begin
                     chk(cycle - rel_cyc == exp_gap, "R3", "settle gap",
                         cycle - rel_cyc, exp_gap);
                     gap_arm = 0;
                  end
               end else if (cmd_reg != q[0][15:8] || cmd_data != q[0][7:0]) begin
                  chk(0, "R5", "fields changed while held", cmd_reg, q[0][15:8]);
               end
            end
         end
      end
      prev_req = cmd_req && !cmd_done;
      prev_rstn = sensor_rst_n;
      // responder
      if (cmd_done) cmd_done = 1'b0;
      else if (cmd_req) begin
         if (rc >= lat) begin cmd_done = 1'b1; rc = 0; end
         else rc++;
      end else rc = 0;
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_data = d;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic pulse_init();
      @(negedge clk); init_req = 1'b1;
      repeat (3) @(negedge clk);
      init_req = 1'b0;
   endtask

   task automatic pulse_freq();
      @(negedge clk); frame_req = 1'b1;
      repeat (3) @(negedge clk);
      frame_req = 1'b0;
   endtask

   task automatic pulse_fdone();
      @(negedge clk); frame_done = 1'b1;
      @(negedge clk); frame_done = 1'b0;
   endtask

   task automatic wait_ph(input int t);
      while (ph != t && !timed_out) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      int base;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(sensor_rst_n == 1'b1, "R9", "sensor_rst_n in reset", sensor_rst_n, 1);
      chk(cmd_req == 1'b0, "R9", "cmd_req in reset", cmd_req, 0);
      chk(img_width_q == 8'h00, "R9", "width in reset", img_width_q, 0);
      rst = 1'b0;
      // R1: configuration; slot 1 left empty so it is skipped (R4)
      wr(4'd2, 8'h09); wr(4'd3, 8'h10);
      wr(4'd4, 8'h09); wr(4'd5, 8'h00);
      wr(4'd8, 8'h12); wr(4'd9, 8'h34);
      wr(4'd10, 8'h20); wr(4'd11, 8'h56);
      wr(4'd12, 8'h21); wr(4'd13, 8'h78);
      wr(4'd14, 8'h50); wr(4'd15, 8'h02);
      chk(img_width_q == 8'h50, "R1", "width after write", img_width_q, 8'h50);
      chk(bytes_per_px == 8'h02, "R1", "bpp after write", bytes_per_px, 2);

      // R2 R3 R4: bring-up, one skipped slot ahead of the first request
      exp_gap = ST + 2; lat = 3;
      pulse_init();
      repeat (30) @(negedge clk);
      // R8: ignored events during bring-up
      pulse_init();
      pulse_freq();
      pulse_fdone();
      wait_ph(2);
      chk(n_sent == 4, "R4", "commands in bring-up", n_sent, 4);

      // R6: frame complete -> sleep
      lat = 0;
      pulse_fdone();
      wait_ph(4);
      chk(n_sent == 5, "R6", "sleep after frame", n_sent, 5);
      // R8: frame_done while parked is ignored
      pulse_fdone();
      repeat (20) @(negedge clk);
      chk(n_sent == 5 && ph == 4, "R8", "frame_done while parked", n_sent, 5);

      // R7: next frame request -> wake, frame -> sleep
      lat = 5;
      pulse_freq();
      wait_ph(2);
      chk(n_sent == 6, "R7", "wake after frame request", n_sent, 6);
      pulse_fdone();
      wait_ph(4);
      chk(n_sent == 7, "R7", "second sleep", n_sent, 7);

      // R9: host reset part way through a frame wait
      pulse_freq();
      wait_ph(2);
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(cmd_req == 1'b0, "R9", "cmd_req under reset", cmd_req, 0);
      chk(sensor_rst_n == 1'b1, "R9", "sensor_rst_n under reset", sensor_rst_n, 1);
      chk(img_width_q == 8'h00, "R9", "width cleared", img_width_q, 0);
      rst = 1'b0;
      wr(4'd6, 8'h30); wr(4'd7, 8'h01);
      wr(4'd4, 8'h0A); wr(4'd5, 8'h02);
      wr(4'd2, 8'h0A); wr(4'd3, 8'h03);
      wr(4'd14, 8'h28); wr(4'd15, 8'h03);
      base = n_sent;
      exp_gap = ST + 1; lat = 1;
      pulse_init();
      wait_ph(2);
      chk(n_sent - base == 2, "R9", "restart sends cmd1 and wake", n_sent - base, 2);
      pulse_fdone();
      wait_ph(4);
      chk(n_sent - base == 3, "R6", "sleep after restart", n_sent - base, 3);
      chk(q.size() == 0, "R4", "expected commands left", q.size(), 0);

      repeat (5) @(negedge clk);
      report();
      $finish;
   end
endmodule